// File: doc/BRIEF.md
# Stream Link Get/Put Controller

This block sits beside a processor pipeline and carries out transfers between the core and a small set of 32-bit streaming links. Each link has an input side (the block reads words from it) and an output side (the block writes words to it). Both sides use a valid/ready handshake. Every word travelling on a link carries a one-bit tag that marks it as a control word or a plain data word. The pipeline hands over one stream instruction word at a time, together with the source operand. The block decodes the word, runs the transfer and reports back through a read-data path with a write enable, a stall line, a one-cycle done pulse and two status flags: carry and a sticky stream-error flag.

A transfer is either a get (read from an input link) or a put (write to an output link). It is also either a control or a data transfer, and either blocking or non-blocking. A blocking transfer holds the pipeline through `stall` until the link can move the word. A non-blocking transfer finishes at once and reports through carry whether the link was able to take part. On a get, if the tag of the received word does not match the flavour that was asked for, the word is still delivered and the error flag is raised.

The controller is a three-state machine. `S_IDLE` accepts a legal stream instruction and moves to `S_GET` or `S_PUT`, chosen by the put/get bit. `S_GET` returns to `S_IDLE` once the selected input link holds a word, or at once in non-blocking mode, and otherwise stays put and stalls. `S_PUT` does the same, waiting on the selected output link's ready. A new instruction is taken only in `S_IDLE`.

Top module: `strm_port_ctrl`

## Requirements
- R1: An instruction is accepted only when `op_valid` is high in `S_IDLE` and bits [31:26] equal 011011. Bit 15 selects put (1) or get (0), bit 14 is the non-blocking flag, bit 13 is the control flag and bits [1:0] give the link index. A word with any other opcode causes no done, no stall and no link activity.
- R2: A blocking get drives `stall` high and `done` low in every cycle in which the selected input link has no word. In the first cycle in which it does, the block raises `in_ready` for that link, `rd_we` and `done` together, with `rd_data` equal to the link's word. `in_ready` is never high for a link whose `in_valid` is low.
- R3: A blocking put holds `out_valid` for the selected link, with `out_data` equal to the operand, stable while `stall` is high. It finishes with `done` in the cycle in which that link's `out_ready` is high.
- R4: A non-blocking get finishes in its first execute cycle. In the following cycle `carry` equals the inverse of the selected link's `in_valid` as seen in that execute cycle. When no word is present, `rd_we` and `in_ready` stay low, so the destination keeps its value.
- R5: A non-blocking put finishes in its first execute cycle. In the following cycle `carry` equals the inverse of the selected link's `out_ready`. A word offered to a link that is not ready is dropped.
- R6: A control put drives `out_tag` 1 and a data put drives `out_tag` 0 while `out_valid` is high.
- R7: A data get that receives a word with tag 1, or a control get that receives a word with tag 0, sets `serr` from the next cycle on, and the word is still delivered. `serr` stays set until a cycle with `err_clr` high and no completing transfer. A new error in the same cycle as `err_clr` wins.
- R8: At most one bit of `in_ready` and at most one bit of `out_valid` is high, and only the bit of the selected link.
- R9: `done` is high for exactly one cycle per accepted instruction. An `op_valid` that arrives while a transfer is in progress is ignored.
- R10: After reset `stall`, `done`, `rd_we`, `carry`, `serr`, `in_ready` and `out_valid` are all low.
- R11: `carry` changes only in the cycle after a non-blocking transfer finishes. Blocking transfers and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction strobe from the pipeline |
| op_insn | input | 32 | Stream instruction word |
| op_wdata | input | DATA_W | Operand sent by a put |
| err_clr | input | 1 | Clears the stream-error flag |
| in_valid | input | NUM_LINKS | Input links: word present |
| in_data | input | NUM_LINKS*DATA_W | Input links: words, link 0 in the low bits |
| in_tag | input | NUM_LINKS | Input links: control tag of each word |
| in_ready | output | NUM_LINKS | Input links: word taken |
| out_valid | output | NUM_LINKS | Output links: word offered |
| out_data | output | DATA_W | Output word, shared by all output links |
| out_tag | output | 1 | Control tag of the output word |
| out_ready | input | NUM_LINKS | Output links: space available (not full) |
| rd_data | output | DATA_W | Word read by a get |
| rd_we | output | 1 | Destination write enable for `rd_data` |
| stall | output | 1 | Pipeline hold while a blocking transfer waits |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Carry flag |
| serr | output | 1 | Sticky stream-error flag |

## Verification
If the state register gets stuck in an execute state, the fault appears at the ports in the very next cycle: `stall` stays high, or `done` repeats, or a link strobe stays up with no request behind it. If the captured link index or flags are wrong, the fault shows up in the first execute cycle, as a strobe on the wrong link, a wrong `out_tag`, or a blocking transfer that finishes without waiting. Faults in the flag registers show up one cycle after the transfer finishes, on `carry` or `serr`. The directed tests sample at each of those points.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int          INSN_W     = 32;
    localparam logic [5:0]  STREAM_OPC = 6'b011011;
    localparam int          OPC_HI     = 31;
    localparam int          OPC_LO     = 26;
    localparam int          PUT_BIT    = 15;
    localparam int          NB_BIT     = 14;
    localparam int          CTRL_BIT   = 13;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_GET  = 2'd1,
        S_PUT  = 2'd2
    } state_e;

    typedef struct packed {
        logic put;
        logic nb;
        logic ctrl;
    } op_flags_t;

endpackage

// File: rtl/spc_decode.sv
module spc_decode
    import spc_pkg::*;
#(
    parameter int LINK_W = 2
) (
    input  logic [INSN_W-1:0] insn,
    output logic              legal,
    output op_flags_t         flags,
    output logic [LINK_W-1:0] link
);

    // Fields that play no part in the transfer itself.
    logic unused_fields;

    assign legal         = (insn[OPC_HI:OPC_LO] == STREAM_OPC);
    assign flags.put     = insn[PUT_BIT];
    assign flags.nb      = insn[NB_BIT];
    assign flags.ctrl    = insn[CTRL_BIT];
    assign link          = insn[LINK_W-1:0];
    assign unused_fields = ^{insn[OPC_LO-1:PUT_BIT+1], insn[CTRL_BIT-1:LINK_W]};

endmodule

// File: rtl/spc_link_mux.sv
module spc_link_mux #(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32,
    parameter int LINK_W    = 2
) (
    input  logic [LINK_W-1:0]           sel,
    input  logic [NUM_LINKS-1:0]        in_valid,
    input  logic [NUM_LINKS*DATA_W-1:0] in_data,
    input  logic [NUM_LINKS-1:0]        in_tag,
    input  logic [NUM_LINKS-1:0]        out_ready,
    input  logic                        get_take,
    input  logic                        put_offer,
    output logic                        sel_valid,
    output logic [DATA_W-1:0]           sel_data,
    output logic                        sel_tag,
    output logic                        sel_ready,
    output logic [NUM_LINKS-1:0]        in_ready,
    output logic [NUM_LINKS-1:0]        out_valid
);

    logic [NUM_LINKS-1:0] hit;
    logic [DATA_W-1:0]    word_arr [NUM_LINKS];

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        assign hit[g]       = (sel == LINK_W'(g));
        assign word_arr[g]  = in_data[g*DATA_W +: DATA_W];
        assign in_ready[g]  = get_take  && hit[g];
        assign out_valid[g] = put_offer && hit[g];
    end

    assign sel_valid = |(in_valid  & hit);
    assign sel_tag   = |(in_tag    & hit);
    assign sel_ready = |(out_ready & hit);
    assign sel_data  = word_arr[sel];

endmodule

// File: rtl/spc_flags.sv
module spc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_we,
    input  logic carry_in,
    input  logic err_set,
    input  logic err_clr,
    output logic carry,
    output logic serr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry <= 1'b0;
            serr  <= 1'b0;
        end else begin
            if (carry_we) begin
                carry <= carry_in;
            end
            // A fresh error takes priority over a clear in the same cycle.
            if (err_set) begin
                serr <= 1'b1;
            end else if (err_clr) begin
                serr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/strm_port_ctrl.sv
module strm_port_ctrl
    import spc_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [31:0]                 op_insn,
    input  logic [DATA_W-1:0]           op_wdata,
    input  logic                        err_clr,
    input  logic [NUM_LINKS-1:0]        in_valid,
    input  logic [NUM_LINKS*DATA_W-1:0] in_data,
    input  logic [NUM_LINKS-1:0]        in_tag,
    output logic [NUM_LINKS-1:0]        in_ready,
    output logic [NUM_LINKS-1:0]        out_valid,
    output logic [DATA_W-1:0]           out_data,
    output logic                        out_tag,
    input  logic [NUM_LINKS-1:0]        out_ready,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_we,
    output logic                        stall,
    output logic                        done,
    output logic                        carry,
    output logic                        serr
);

    localparam int LINK_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

    state_e            state_q, state_d;
    op_flags_t         dec_flags, flags_q;
    logic [LINK_W-1:0] dec_link, link_q;
    logic [DATA_W-1:0] wdata_q;
    logic              dec_legal;
    logic              accept;

    logic              sel_valid, sel_tag, sel_ready;
    logic [DATA_W-1:0] sel_data;
    logic              get_take, put_offer;
    logic              carry_we, carry_in, err_set;

    spc_decode #(.LINK_W(LINK_W)) u_decode (
        .insn  (op_insn),
        .legal (dec_legal),
        .flags (dec_flags),
        .link  (dec_link)
    );

    spc_link_mux #(
        .NUM_LINKS (NUM_LINKS),
        .DATA_W    (DATA_W),
        .LINK_W    (LINK_W)
    ) u_mux (
        .sel       (link_q),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_tag    (in_tag),
        .out_ready (out_ready),
        .get_take  (get_take),
        .put_offer (put_offer),
        .sel_valid (sel_valid),
        .sel_data  (sel_data),
        .sel_tag   (sel_tag),
        .sel_ready (sel_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    spc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry_we (carry_we),
        .carry_in (carry_in),
        .err_set  (err_set),
        .err_clr  (err_clr),
        .carry    (carry),
        .serr     (serr)
    );

    assign accept = op_valid && dec_legal && (state_q == S_IDLE);

    // State register and the operation captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            flags_q <= '0;
            link_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                flags_q <= dec_flags;
                link_q  <= dec_link;
                wdata_q <= op_wdata;
            end
        end
    end

    // Outputs and next state.
    always_comb begin
        state_d   = state_q;
        get_take  = 1'b0;
        put_offer = 1'b0;
        rd_we     = 1'b0;
        done      = 1'b0;
        stall     = 1'b0;
        carry_we  = 1'b0;
        carry_in  = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = dec_flags.put ? S_PUT : S_GET;
                end
            end
            S_GET: begin
                if (sel_valid) begin
                    get_take = 1'b1;
                    rd_we    = 1'b1;
                    done     = 1'b1;
                    carry_we = flags_q.nb;
                    carry_in = 1'b0;
                    err_set  = (sel_tag != flags_q.ctrl);
                    state_d  = S_IDLE;
                end else if (flags_q.nb) begin
                    done     = 1'b1;
                    carry_we = 1'b1;
                    carry_in = 1'b1;
                    state_d  = S_IDLE;
                end else begin
                    stall    = 1'b1;
                end
            end
            S_PUT: begin
                put_offer = 1'b1;
                if (sel_ready) begin
                    done     = 1'b1;
                    carry_we = flags_q.nb;
                    carry_in = 1'b0;
                    state_d  = S_IDLE;
                end else if (flags_q.nb) begin
                    done     = 1'b1;
                    carry_we = 1'b1;
                    carry_in = 1'b1;
                    state_d  = S_IDLE;
                end else begin
                    stall    = 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    assign rd_data  = sel_data;
    assign out_data = wdata_q;
    assign out_tag  = put_offer && flags_q.ctrl;

endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINKS-1:0] in_valid,
    input logic [NUM_LINKS-1:0] in_ready,
    input logic [NUM_LINKS-1:0] out_valid,
    input logic [NUM_LINKS-1:0] out_ready,
    input logic [DATA_W-1:0]    out_data,
    input logic                 stall,
    input logic                 done,
    input logic                 carry,
    input logic                 serr,
    input logic                 err_clr
);

    p_one_in_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    p_one_out_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    p_ready_needs_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == '0);

    p_stall_excludes_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_put_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && (out_valid != '0) && ((out_valid & out_ready) == '0))
        |=> (out_valid == $past(out_valid)) && $stable(out_data));

    p_serr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (serr && !err_clr) |=> serr);

    p_serr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !done) |=> !serr);

    p_carry_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(carry));

endmodule

bind strm_port_ctrl spc_chk #(
    .NUM_LINKS (NUM_LINKS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .stall     (stall),
    .done      (done),
    .carry     (carry),
    .serr      (serr),
    .err_clr   (err_clr)
);

// File: tb/strm_port_ctrl_tb.sv
`timescale 1ns/1ps
module strm_port_ctrl_tb;

    localparam int NL = 4;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [31:0]     op_insn = '0;
    logic [DW-1:0]   op_wdata = '0;
    logic            err_clr = 1'b0;
    logic [NL-1:0]   in_valid = '0;
    logic [NL*DW-1:0] in_data;
    logic [NL-1:0]   in_tag = '0;
    logic [NL-1:0]   in_ready;
    logic [NL-1:0]   out_valid;
    logic [DW-1:0]   out_data;
    logic            out_tag;
    logic [NL-1:0]   out_ready = '0;
    logic [DW-1:0]   rd_data;
    logic            rd_we, stall, done, carry, serr;

    logic [DW-1:0]   lk_word [NL];
    logic [DW-1:0]   dest;
    int              checks = 0;
    int              errors = 0;
    bit              finished = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) in_data[i*DW +: DW] = lk_word[i];
    end

    // Destination register model written by rd_we.
    always @(posedge clk) begin
        if (!rst_n) dest <= 32'hDEAD_0000;
        else if (rd_we) dest <= rd_data;
    end

    strm_port_ctrl #(.NUM_LINKS(NL), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_insn(op_insn),
        .op_wdata(op_wdata), .err_clr(err_clr), .in_valid(in_valid),
        .in_data(in_data), .in_tag(in_tag), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag),
        .out_ready(out_ready), .rd_data(rd_data), .rd_we(rd_we),
        .stall(stall), .done(done), .carry(carry), .serr(serr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic put, input logic nb, input logic ctl,
                                       input logic [1:0] lk);
        return {6'b011011, 5'd3, 5'd4, put, nb, ctl, 11'd0, lk};
    endfunction

    task automatic step();
        @(negedge clk); #1;
    endtask

    // Presents one instruction for one cycle; returns in the first execute cycle.
    task automatic issue(input logic [31:0] insn, input logic [31:0] wd);
        @(negedge clk);
        op_valid = 1'b1; op_insn = insn; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0; #1;
    endtask

    task automatic t_reset();
        chk("R10 stall", stall, 0);   chk("R10 done", done, 0);
        chk("R10 rd_we", rd_we, 0);   chk("R10 carry", carry, 0);
        chk("R10 serr", serr, 0);     chk("R10 in_ready", in_ready, 0);
        chk("R10 out_valid", out_valid, 0);
    endtask

    task automatic t_blocking_get();
        in_valid = 4'b0010; lk_word[1] = 32'h1111_1111; in_tag = '0;
        issue(mk(0, 0, 0, 2), 0);
        for (int i = 0; i < 3; i++) begin
            chk("R2 stall while empty", stall, 1);
            chk("R2 no done while empty", done, 0);
            chk("R8 no ready while empty", in_ready, 0);
            step();
        end
        lk_word[2] = 32'hA5A5_0001; in_valid = 4'b0110; #1;
        chk("R2 done on arrival", done, 1);
        chk("R2 rd_we on arrival", rd_we, 1);
        chk("R2 rd_data", rd_data, 32'hA5A5_0001);
        chk("R8 ready only on link 2", in_ready, 4'b0100);
        chk("R2 stall released", stall, 0);
        step(); in_valid = '0; #1;
        chk("R2 destination written", dest, 32'hA5A5_0001);
        chk("R9 done gone", done, 0);
        chk("R11 carry kept by blocking get", carry, 0);
        chk("R7 matched tag no error", serr, 0);
    endtask

    task automatic t_nb_get();
        in_valid = '0;
        issue(mk(0, 1, 0, 0), 0);
        chk("R4 nb get done", done, 1);
        chk("R4 nb get no stall", stall, 0);
        chk("R4 nb get empty no rd_we", rd_we, 0);
        chk("R4 nb get empty no ready", in_ready, 0);
        step();
        chk("R4 carry set when empty", carry, 1);
        chk("R4 destination unchanged", dest, 32'hA5A5_0001);
        // Blocking get with carry at 1 keeps it (R11).
        lk_word[3] = 32'h3333_0003; in_valid = 4'b1000;
        issue(mk(0, 0, 0, 3), 0);
        chk("R2 blocking get immediate", done, 1);
        step(); in_valid = '0; #1;
        chk("R11 carry kept", carry, 1);
        lk_word[3] = 32'h3333_0004; in_valid = 4'b1000;
        issue(mk(0, 1, 0, 3), 0);
        chk("R4 nb get with word rd_we", rd_we, 1);
        chk("R4 nb get ready", in_ready, 4'b1000);
        step(); in_valid = '0; #1;
        chk("R4 carry clear when word present", carry, 0);
        chk("R4 destination written", dest, 32'h3333_0004);
    endtask

    task automatic t_blocking_put();
        out_ready = '0;
        issue(mk(1, 0, 1, 1), 32'hC0DE_0001);
        for (int i = 0; i < 2; i++) begin
            chk("R3 out_valid link 1", out_valid, 4'b0010);
            chk("R3 out_data", out_data, 32'hC0DE_0001);
            chk("R6 control tag", out_tag, 1);
            chk("R3 stall while full", stall, 1);
            step();
        end
        out_ready = 4'b1111; #1;
        chk("R3 done on space", done, 1);
        chk("R8 only link 1 offered", out_valid, 4'b0010);
        step(); out_ready = '0; #1;
        chk("R3 offer withdrawn", out_valid, 0);
        chk("R11 carry kept by blocking put", carry, 0);
    endtask

    task automatic t_nb_put();
        out_ready = 4'b1110;
        issue(mk(1, 1, 0, 0), 32'hBAD0_0002);
        chk("R5 nb put done", done, 1);
        chk("R6 data tag", out_tag, 0);
        chk("R5 word dropped", out_valid & out_ready, 0);
        step();
        chk("R5 carry set when full", carry, 1);
        chk("R5 no retry", out_valid, 0);
        out_ready = 4'b1111;
        issue(mk(1, 1, 0, 3), 32'h600D_0003);
        chk("R5 nb put accepted", out_valid & out_ready, 4'b1000);
        chk("R1 link index bits", out_valid, 4'b1000);
        step(); out_ready = '0; #1;
        chk("R5 carry clear when space", carry, 0);
    endtask

    task automatic t_stream_error();
        lk_word[0] = 32'hE000_0001; in_tag = 4'b0001; in_valid = 4'b0001;
        issue(mk(0, 0, 0, 0), 0);
        chk("R7 word delivered despite tag", rd_we, 1);
        step(); in_valid = '0; #1;
        chk("R7 data get tag 1 sets error", serr, 1);
        in_valid = 4'b0001;
        issue(mk(0, 0, 1, 0), 0);
        step(); in_valid = '0; #1;
        chk("R7 error sticky", serr, 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0; #1;
        chk("R7 error cleared", serr, 0);
        in_tag = '0; in_valid = 4'b0001;
        issue(mk(0, 0, 1, 0), 0);
        step(); in_valid = '0; #1;
        chk("R7 control get tag 0 sets error", serr, 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0; #1;
        chk("R7 error cleared again", serr, 0);
    endtask

    task automatic t_illegal();
        in_valid = 4'b0010; out_ready = 4'b1111;
        issue(mk(0, 1, 0, 1) ^ 32'h0400_0000, 0);
        chk("R1 foreign opcode no done", done, 0);
        chk("R1 foreign opcode no stall", stall, 0);
        chk("R1 foreign opcode no ready", in_ready, 0);
        step();
        chk("R1 foreign opcode still idle", done, 0);
        in_valid = '0; out_ready = '0;
    endtask

    task automatic t_busy_ignore();
        in_valid = '0; out_ready = 4'b1111;
        issue(mk(0, 0, 0, 2), 0);
        @(negedge clk); op_valid = 1'b1; op_insn = mk(1, 1, 0, 3);
        @(negedge clk); op_valid = 1'b0; #1;
        chk("R9 still waiting", stall, 1);
        chk("R9 intruding put not run", out_valid, 0);
        lk_word[2] = 32'h2222_0002; in_valid = 4'b0100; #1;
        chk("R9 get completes", done, 1);
        step(); in_valid = '0; #1;
        chk("R9 no second done", done, 0);
        chk("R9 put never offered", out_valid, 0);
        out_ready = '0;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) lk_word[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_blocking_get();
        t_nb_get();
        t_blocking_put();
        t_nb_put();
        t_stream_error();
        t_illegal();
        t_busy_ignore();
        step();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule